// File: doc/BRIEF.md
# Management-Interface PHY Register Model

This block stands in for one Ethernet PHY's register file, reached through a single 32-bit management-frame register. A write strobe on the register-bus port delivers one frame. The block decodes from the frame an operation bit, a 10-bit register select and 16 bits of data. It reads or writes the selected PHY register in the same clock edge. For a read, it places the result in the low half of the frame register. In the next cycle it raises a one-cycle management-done event.

A link-level input drives the link and autonegotiation status bits and the latched interrupt-source bits. The interrupt-source register clears when it is read. A PHY interrupt output is high whenever any pending source bit is enabled by the interrupt mask. Register writes go through per-register masks, and some registers have bits that are always forced to one.

Top module: `mgmt_phy_model`

## Requirements
- R1: Frame fields: bit 29 = 1 selects a read and 0 selects a write. The register select is bits 27:18, and the write data is bits 15:0. The other bits have no effect.
- R2: `done_o` is high for exactly the one cycle that follows each cycle with `wr_en_i` high. It is low at every other time.
- R3: In the cycle after a frame write, `frame_o[31:16]` equals the written bits 31:16. For a read, `frame_o[15:0]` holds the register's value from before the access. For a write, it holds the written data. `frame_o` keeps its value between frames and is zero after reset.
- R4: Reset values are: control 0x3000, status 0x7809, advertisement 0x01E1, mask 0, interrupt source 0.
- R5: A link event happens on the first cycle after reset and on every change of `link_up_i`. For link up, the event sets status bits 5 and 2 and sets source bits 7 and 6. For link down, it clears status bits 5 and 2 and sets source bit 4.
- R6: A constant link level creates no further link event. Source bits that a read has cleared stay clear.
- R7: Register 2 reads 0x0007, register 3 reads 0xC0D1, register 5 reads 0x0F71 and register 6 reads 0x0001.
- R8: Every select other than 0, 1, 2, 3, 4, 5, 6, 29 and 30 reads as zero, including all selects above 31. Writes to any select other than 0, 4 and 30 change no register.
- R9: A write to register 0 with bit 15 set restores all R4 values and then applies a link event for the current link level. Any other write to register 0 stores data & 0x7980, and if data bit 12 is set, it also sets status bit 5.
- R10: A write to register 4 stores (data & 0x2D7F) | 0x0080. A write to register 30 stores data & 0x00FF.
- R11: A read of register 29 returns the pending source bits and clears them. Bits set by a link event in the same cycle survive the clear.
- R12: `phy_irq_o` is high exactly when (source & mask) is non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Frame register write strobe |
| wr_data_i | input | 32 | Management frame written |
| link_up_i | input | 1 | Link level, 1 = up |
| frame_o | output | 32 | Frame register readback |
| done_o | output | 1 | Management-done event, one cycle |
| phy_irq_o | output | 1 | PHY interrupt |

## Verification
The hardest behaviour to reach from the ports is the interaction between the latched interrupt-source bits and the link edge detector. It must be shown that a link level held for many cycles does not set the bits again after a clearing read. It must also be shown that a control reset re-applies the link level without any edge on the input. The stimulus reads register 29 twice around a long stable link interval. It toggles the link with a mask that enables only the down bit. It issues a control reset while the link is up. Around these steps it sweeps reads over all 1024 register selects against a model kept in the bench.

// File: rtl/mphy_pkg.sv
package mphy_pkg;
  parameter int FRAME_W = 32;
  parameter int DATA_W  = 16;
  parameter int SEL_W   = 10;
  parameter int SEL_LSB = 18;
  parameter int OP_BIT  = 29;

  localparam logic [DATA_W-1:0] CTL_RST  = 16'h3000;
  localparam logic [DATA_W-1:0] STAT_RST = 16'h7809;
  localparam logic [DATA_W-1:0] ADV_RST  = 16'h01E1;
  localparam logic [DATA_W-1:0] CTL_WMASK = 16'h7980;
  localparam logic [DATA_W-1:0] ADV_WMASK = 16'h2D7F;
  localparam logic [DATA_W-1:0] ADV_FORCE = 16'h0080;
  localparam logic [DATA_W-1:0] MASK_WMASK = 16'h00FF;
  localparam logic [DATA_W-1:0] STAT_LINK = 16'h0024;
  localparam logic [DATA_W-1:0] STAT_ANEG = 16'h0020;
  localparam logic [DATA_W-1:0] SRC_UP    = 16'h00C0;
  localparam logic [DATA_W-1:0] SRC_DOWN  = 16'h0010;

  typedef struct packed {
    logic              is_read;
    logic [SEL_W-1:0]  sel;
    logic [DATA_W-1:0] wdata;
  } frame_t;
endpackage

// File: rtl/mphy_frame_dec.sv
module mphy_frame_dec
  import mphy_pkg::*;
(
  input  logic [FRAME_W-1:0] frame_i,
  output frame_t             fld_o
);
  always_comb begin
    fld_o.is_read = frame_i[OP_BIT];
    fld_o.sel     = frame_i[SEL_LSB +: SEL_W];
    fld_o.wdata   = frame_i[DATA_W-1:0];
  end
endmodule

// File: rtl/mphy_link_det.sv
module mphy_link_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic link_i,
  input  logic soft_rst_i,
  output logic apply_o,
  output logic link_q_o,
  output logic init_q_o
);
  logic link_q, init_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      link_q <= 1'b0;
      init_q <= 1'b1;
    end else begin
      link_q <= link_i;
      init_q <= 1'b0;
    end
  end

  // first cycle after reset, any edge, or a control-register reset
  assign apply_o  = init_q | (link_i != link_q) | soft_rst_i;
  assign link_q_o = link_q;
  assign init_q_o = init_q;
endmodule

// File: rtl/mphy_regfile.sv
module mphy_regfile
  import mphy_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              acc_i,
  input  frame_t            fld_i,
  input  logic              apply_i,
  input  logic              link_i,
  output logic              soft_rst_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic [DATA_W-1:0] adv_o,
  output logic [DATA_W-1:0] mask_o,
  output logic [DATA_W-1:0] src_o
);
  localparam int NREG = 32;

  logic [DATA_W-1:0] ctl_q, stat_q, adv_q, mask_q, src_q;
  logic [DATA_W-1:0] ctl_d, stat_d, adv_d, mask_d, src_d;
  logic              wr, rd, in_range;
  logic [4:0]        idx;

  assign in_range   = (fld_i.sel < SEL_W'(NREG));
  assign idx        = fld_i.sel[4:0];
  assign wr         = acc_i & ~fld_i.is_read & in_range;
  assign rd         = acc_i &  fld_i.is_read & in_range;
  assign soft_rst_o = wr & (idx == 5'd0) & fld_i.wdata[15];

  always_comb begin
    rdata_o = '0;
    if (in_range) begin
      unique case (idx)
        5'd0:    rdata_o = ctl_q;
        5'd1:    rdata_o = stat_q;
        5'd2:    rdata_o = 16'h0007;
        5'd3:    rdata_o = 16'hC0D1;
        5'd4:    rdata_o = adv_q;
        5'd5:    rdata_o = 16'h0F71;
        5'd6:    rdata_o = 16'h0001;
        5'd29:   rdata_o = src_q;
        5'd30:   rdata_o = mask_q;
        default: rdata_o = '0;
      endcase
    end
  end

  always_comb begin
    ctl_d  = ctl_q;
    stat_d = stat_q;
    adv_d  = adv_q;
    mask_d = mask_q;
    src_d  = src_q;
    if (soft_rst_o) begin
      ctl_d  = CTL_RST;
      stat_d = STAT_RST;
      adv_d  = ADV_RST;
      mask_d = '0;
      src_d  = '0;
    end else if (wr) begin
      unique case (idx)
        5'd0: begin
          ctl_d = fld_i.wdata & CTL_WMASK;
          if (fld_i.wdata[12]) stat_d = stat_q | STAT_ANEG;
        end
        5'd4:    adv_d  = (fld_i.wdata & ADV_WMASK) | ADV_FORCE;
        5'd30:   mask_d = fld_i.wdata & MASK_WMASK;
        default: ;
      endcase
    end else if (rd && idx == 5'd29) begin
      src_d = '0;
    end
    // link event applied last so its bits survive a clearing read
    if (apply_i) begin
      if (link_i) begin
        stat_d = stat_d | STAT_LINK;
        src_d  = src_d | SRC_UP;
      end else begin
        stat_d = stat_d & ~STAT_LINK;
        src_d  = src_d | SRC_DOWN;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q  <= CTL_RST;
      stat_q <= STAT_RST;
      adv_q  <= ADV_RST;
      mask_q <= '0;
      src_q  <= '0;
    end else begin
      ctl_q  <= ctl_d;
      stat_q <= stat_d;
      adv_q  <= adv_d;
      mask_q <= mask_d;
      src_q  <= src_d;
    end
  end

  assign adv_o  = adv_q;
  assign mask_o = mask_q;
  assign src_o  = src_q;
endmodule

// File: rtl/mgmt_phy_model.sv
module mgmt_phy_model
  import mphy_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [FRAME_W-1:0] wr_data_i,
  input  logic               link_up_i,
  output logic [FRAME_W-1:0] frame_o,
  output logic               done_o,
  output logic               phy_irq_o
);
  frame_t            fld;
  logic              apply, soft_rst, link_q, init_q;
  logic [DATA_W-1:0] rdata, adv_q, mask_q, int_q;
  logic [FRAME_W-1:0] frame_q;
  logic               done_q;

  mphy_frame_dec u_dec (
    .frame_i (wr_data_i),
    .fld_o   (fld)
  );

  mphy_link_det u_link (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .link_i     (link_up_i),
    .soft_rst_i (soft_rst),
    .apply_o    (apply),
    .link_q_o   (link_q),
    .init_q_o   (init_q)
  );

  mphy_regfile u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .acc_i      (wr_en_i),
    .fld_i      (fld),
    .apply_i    (apply),
    .link_i     (link_up_i),
    .soft_rst_o (soft_rst),
    .rdata_o    (rdata),
    .adv_o      (adv_q),
    .mask_o     (mask_q),
    .src_o      (int_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frame_q <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= wr_en_i;
      if (wr_en_i)
        frame_q <= {wr_data_i[FRAME_W-1:DATA_W],
                    fld.is_read ? rdata : wr_data_i[DATA_W-1:0]};
    end
  end

  assign frame_o   = frame_q;
  assign done_o    = done_q;
  assign phy_irq_o = |(int_q & mask_q);
endmodule

// File: rtl/mphy_chk.sv
module mphy_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        wr_en_i,
  input logic [31:0] wr_data_i,
  input logic        link_up_i,
  input logic [31:0] frame_o,
  input logic        done_o,
  input logic [15:0] adv_q,
  input logic [15:0] int_q,
  input logic        link_q,
  input logic        init_q
);
  // R2
  done_follows_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> done_o);
  // R2
  no_spurious_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> !done_o);
  // R3
  upper_kept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> frame_o[31:16] == $past(wr_data_i[31:16]));
  // R3
  frame_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(frame_o));
  // R10
  adv_forced_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_q[7] && ((adv_q & ~16'h2DFF) == 16'h0));
  // R11
  clear_on_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_data_i[29] && wr_data_i[27:18] == 10'd29 &&
     link_up_i == link_q && !init_q) |=> int_q == 16'h0);
  // R6
  stable_link_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!init_q && link_up_i == link_q && !wr_en_i) |=> $stable(int_q));
endmodule

bind mgmt_phy_model mphy_chk u_chk (.*);

// File: tb/tb_mgmt_phy_model.sv
module tb_mgmt_phy_model;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [31:0] wr_data_i = '0;
  logic        link_up_i = 1'b0;
  logic [31:0] frame_o;
  logic        done_o, phy_irq_o;

  int checks = 0;
  int fails = 0;
  logic [15:0] m_ctl, m_stat, m_adv, m_mask, m_src;
  logic        m_link;

  always #2 clk_i = ~clk_i;

  mgmt_phy_model dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic m_reset();
    m_ctl = 16'h3000; m_stat = 16'h7809; m_adv = 16'h01E1;
    m_mask = 16'h0; m_src = 16'h0;
  endtask

  task automatic m_link_ev();
    if (m_link) begin m_stat |= 16'h0024; m_src |= 16'h00C0; end
    else begin m_stat &= ~16'h0024; m_src |= 16'h0010; end
  endtask

  function automatic logic [15:0] m_read(input int sel);
    case (sel)
      0: return m_ctl;
      1: return m_stat;
      2: return 16'h0007;
      3: return 16'hC0D1;
      4: return m_adv;
      5: return 16'h0F71;
      6: return 16'h0001;
      29: return m_src;
      30: return m_mask;
      default: return 16'h0;
    endcase
  endfunction

  function automatic logic [15:0] irq_exp();
    return {15'h0, |(m_src & m_mask)};
  endfunction

  // drive one frame, sample result a full cycle later, update the model
  task automatic access(input string req, input bit rd, input int sel,
                        input logic [15:0] d, input logic [1:0] hi);
    logic [31:0] f;
    logic [15:0] exp_lo;
    f = {hi, rd, 1'b1, sel[9:0], 2'b10, d};
    exp_lo = rd ? m_read(sel) : d;
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_data_i = f;
    @(negedge clk_i);
    wr_en_i = 1'b0; wr_data_i = ~f;
    chk({req, " R3 frame"}, frame_o, {f[31:16], exp_lo});
    chk("R2 done", {31'h0, done_o}, 32'h1);
    if (rd) begin
      if (sel == 29) m_src = 16'h0;
    end else begin
      case (sel)
        0: if (d[15]) begin m_reset(); m_link_ev(); end
           else begin m_ctl = d & 16'h7980; if (d[12]) m_stat |= 16'h0020; end
        4: m_adv = (d & 16'h2D7F) | 16'h0080;
        30: m_mask = d & 16'h00FF;
        default: ;
      endcase
    end
    chk({req, " R12 irq"}, {31'h0, phy_irq_o}, {16'h0, irq_exp()});
  endtask

  task automatic set_link(input logic v);
    @(negedge clk_i);
    link_up_i = v;
    @(negedge clk_i);
    m_link = v;
    m_link_ev();
    chk("R12 irq after link", {31'h0, phy_irq_o}, {16'h0, irq_exp()});
  endtask

  task automatic sweep(input string req);
    for (int s = 0; s < 1024; s++) begin
      if (s != 29) access(req, 1'b1, s, 16'hA5A5, s[1:0]);
    end
  endtask

  initial begin
    #(4 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    m_reset(); m_link = 1'b0;
    repeat (3) @(negedge clk_i);
    chk("R4 frame reset", frame_o, 32'h0);
    chk("R2 done reset", {31'h0, done_o}, 32'h0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    m_link_ev(); // R5 first-cycle event with link down
    @(negedge clk_i);
    chk("R2 idle", {31'h0, done_o}, 32'h0);
    // R4 R5 R7 R8 R1: full read sweep after reset
    access("R11 src after reset", 1'b1, 29, 16'h0, 2'b11);
    sweep("R8 reset sweep");
    // R5 R6 link up, then held
    set_link(1'b1);
    access("R5 status up", 1'b1, 1, 16'h0, 2'b00);
    repeat (20) @(negedge clk_i);
    access("R11 src up", 1'b1, 29, 16'h0, 2'b01);
    repeat (20) @(negedge clk_i);
    access("R6 src held", 1'b1, 29, 16'h0, 2'b10);
    // R12 mask only the down bit
    access("R10 mask", 1'b0, 30, 16'hFF10, 2'b00);
    access("R10 mask rd", 1'b1, 30, 16'h0, 2'b00);
    set_link(1'b0);
    chk("R12 irq high", {31'h0, phy_irq_o}, 32'h1);
    access("R11 clear", 1'b1, 29, 16'h0, 2'b00);
    chk("R12 irq low", {31'h0, phy_irq_o}, 32'h0);
    // R9 control write with autoneg bit
    access("R9 ctl", 1'b0, 0, 16'h7FFF, 2'b00);
    access("R9 ctl rd", 1'b1, 0, 16'h0, 2'b00);
    access("R9 status bit5", 1'b1, 1, 16'h0, 2'b00);
    access("R9 ctl nobit12", 1'b0, 0, 16'h0A5A, 2'b01);
    // R10 advertisement
    access("R10 adv ones", 1'b0, 4, 16'hFFFF, 2'b00);
    access("R10 adv rd", 1'b1, 4, 16'h0, 2'b00);
    access("R10 adv zero", 1'b0, 4, 16'h0000, 2'b00);
    access("R10 adv rd0", 1'b1, 4, 16'h0, 2'b00);
    // R8 ignored writes, R1 op bit
    access("R8 wr c2", 1'b0, 2, 16'hFFFF, 2'b11);
    access("R8 wr 17", 1'b0, 17, 16'hFFFF, 2'b11);
    access("R8 wr 29", 1'b0, 29, 16'hFFFF, 2'b11);
    access("R8 wr 31", 1'b0, 31, 16'hFFFF, 2'b11);
    access("R8 wr 1", 1'b0, 1, 16'hFFFF, 2'b11);
    access("R8 wr 32", 1'b0, 32, 16'h8000, 2'b11);
    access("R8 wr 1023", 1'b0, 1023, 16'hFFFF, 2'b11);
    access("R1 wr 96", 1'b0, 96, 16'hFFFF, 2'b10);
    sweep("R8 post-write sweep");
    // R9 soft reset while link up re-applies link
    set_link(1'b1);
    access("R11 clear up", 1'b1, 29, 16'h0, 2'b00);
    access("R9 soft reset", 1'b0, 0, 16'h8000, 2'b00);
    access("R9 src after soft", 1'b1, 29, 16'h0, 2'b00);
    sweep("R9 soft reset sweep");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule